// File: doc/BRIEF.md
# Twisted-Pair Link Pulse Generator and Integrity Monitor

This block keeps a 10 Mb/s twisted-pair port alive while it has nothing to send, and decides whether the far end is present. On the transmit side it asks the line driver for a short idle pulse at a fixed cadence. Any transmit traffic suppresses these pulses, and the cadence starts over when the transmitter falls quiet. On the receive side it takes a strobe for each pulse the upstream slicer recognises, plus a flag for packet activity. From these it drives a link-good status, normally used to light an LED and to gate the data path.

All millisecond timing comes from one free-running prescaler that produces a tick every `TICK_DIV` clocks (25000 clocks at 25 MHz gives 1 ms). Every interval is a parameter counted in ticks, so a bench can shorten all of them together. There is no data stream: every pin is a plain level or strobe, and nothing can be back-pressured.

Top module: `tlp_link_pulse`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tx_pulse_req`, `tx_pulse_en` and `link_good` are all 0.
- R2: With `tx_active` held low, `tx_pulse_req` is high for exactly one clock per pulse. Consecutive requests are exactly `TX_GAP*TICK_DIV` clocks apart. After reset the first request comes at most `TX_GAP*TICK_DIV+2` clocks after reset is released.
- R3: `tx_pulse_en` rises in the same cycle as `tx_pulse_req` and stays high for exactly `PULSE_CLKS` clocks, unless transmit activity cuts it short.
- R4: In the cycle after `tx_active` is high, neither `tx_pulse_req` nor `tx_pulse_en` is high, so a pending pulse is cancelled. After the last active cycle, the next request comes between `(TX_GAP-1)*TICK_DIV` and `TX_GAP*TICK_DIV+2` clocks later.
- R5: The spacing of a received pulse is the number of ticks since the previous received pulse. A spacing from `MIN_GAP` to `MAX_GAP` ticks, inclusive, is valid. `link_good` is set one cycle after a pulse that completes two valid spacings in a row. After reset or link loss, the first pulse only serves as the reference for the next one.
- R6: A pulse with a spacing below `MIN_GAP` ticks does not count. It clears the count of valid spacings and becomes the new reference, and it does not raise `link_good`.
- R7: A pulse with a spacing above `MAX_GAP` ticks is a spacing violation. It clears the count of valid spacings and becomes the new reference.
- R8: A cycle with `rx_active` high sets `link_good` in the next cycle. `link_good` stays set for as long as `rx_active` stays high.
- R9: If neither `rx_active` nor `rx_pulse` is seen for `LOSS_TICKS` ticks, `link_good` clears and the pulse reference is forgotten. This happens between `(LOSS_TICKS-1)*TICK_DIV` and `LOSS_TICKS*TICK_DIV+2` clocks after the last activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Transmitter is sending a packet |
| rx_active | input | 1 | Receiver sees packet activity |
| rx_pulse | input | 1 | One-clock strobe per received link pulse |
| tx_pulse_req | output | 1 | One-clock request to emit a link pulse |
| tx_pulse_en | output | 1 | Pulse-width enable for the line driver |
| link_good | output | 1 | Link integrity status |

## Verification
The bench builds the block with `TICK_DIV=10`, `TX_GAP=16`, `PULSE_CLKS=3`, `MIN_GAP=5`, `MAX_GAP=20` and `LOSS_TICKS=40`. With these values the idle cadence is 160 clocks and link loss takes about 400 clocks. Cancelled pulses, early pulses, late pulses and loss events therefore all fit into a few thousand cycles. `LOSS_TICKS` is set well above `MAX_GAP` on purpose, so that a late-pulse violation can be seen apart from a link-loss event. The received spacings used (20, 100 and 300 clocks) are chosen to stay clear of the tick-boundary ambiguity at each window edge.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  // Verdict on the spacing of a received link pulse.
  typedef enum logic [1:0] {
    SPC_NONE  = 2'd0,  // no reference pulse yet
    SPC_EARLY = 2'd1,  // closer than the minimum window
    SPC_OK    = 2'd2,  // inside the accepted window
    SPC_LATE  = 2'd3   // beyond the maximum window
  } spacing_e;
endpackage

// File: rtl/tlp_tick_gen.sv
module tlp_tick_gen #(
  parameter int unsigned TICK_DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == CW'(TICK_DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == CW'(TICK_DIV - 1));

      // R9: the timers depend on ticks being isolated strobes
      p_tick_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tlp_tx_sched.sv
module tlp_tx_sched #(
  parameter int unsigned TX_GAP     = 16,
  parameter int unsigned PULSE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_active,
  output logic tx_pulse_req,
  output logic tx_pulse_en
);
  localparam int unsigned GW = $clog2(TX_GAP + 1);
  localparam int unsigned WW = $clog2(PULSE_CLKS + 1);

  logic [GW-1:0] gap_cnt;
  logic [WW-1:0] wid_cnt;
  logic          req_q;
  logic          fire;

  // Idle cadence reached: schedule a pulse for the next cycle.
  assign fire = tick && !tx_active && (gap_cnt == GW'(TX_GAP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      wid_cnt <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= fire;
      // Traffic holds the cadence at zero; it restarts once idle.
      if (tx_active) gap_cnt <= '0;
      else if (tick) gap_cnt <= fire ? '0 : gap_cnt + 1'b1;
      // Width counter; traffic cuts a pulse in progress.
      if (tx_active) wid_cnt <= '0;
      else if (fire) wid_cnt <= WW'(PULSE_CLKS);
      else if (wid_cnt != '0) wid_cnt <= wid_cnt - 1'b1;
    end
  end

  assign tx_pulse_req = req_q;
  assign tx_pulse_en  = (wid_cnt != '0);

  p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse_req |=> !tx_pulse_req);

  p_en_starts_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pulse_en) |-> tx_pulse_req);

  p_quiet_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> (!tx_pulse_req && !tx_pulse_en));
endmodule

// File: rtl/tlp_rx_judge.sv
module tlp_rx_judge
  import tlp_pkg::*;
#(
  parameter int unsigned MIN_GAP    = 5,
  parameter int unsigned MAX_GAP    = 52,
  parameter int unsigned LOSS_TICKS = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_active,
  input  logic rx_pulse,
  output logic link_good
);
  localparam int unsigned SW  = $clog2(MAX_GAP + 2);
  localparam int unsigned LW  = $clog2(LOSS_TICKS + 1);
  localparam logic [SW-1:0] SAT = SW'(MAX_GAP + 1);

  logic [SW-1:0] since;     // ticks since the reference pulse, saturating
  logic [LW-1:0] idle_cnt;  // ticks since any receive activity
  logic          have_ref;
  logic          one_ok;    // one valid spacing already seen
  logic          link_q;
  logic          loss_hit;
  spacing_e      verdict;

  always_comb begin
    if (!have_ref)                    verdict = SPC_NONE;
    else if (since < SW'(MIN_GAP))    verdict = SPC_EARLY;
    else if (since > SW'(MAX_GAP))    verdict = SPC_LATE;
    else                              verdict = SPC_OK;
  end

  assign loss_hit = tick && !rx_active && !rx_pulse &&
                    (idle_cnt == LW'(LOSS_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since    <= '0;
      idle_cnt <= '0;
      have_ref <= 1'b0;
      one_ok   <= 1'b0;
      link_q   <= 1'b0;
    end else begin
      if (rx_active || rx_pulse) idle_cnt <= '0;
      else if (tick) idle_cnt <= loss_hit ? '0 : idle_cnt + 1'b1;

      if (rx_pulse) since <= '0;
      else if (tick && since != SAT) since <= since + 1'b1;

      if (loss_hit) begin
        have_ref <= 1'b0;
        one_ok   <= 1'b0;
        link_q   <= 1'b0;
      end else begin
        if (rx_pulse) begin
          have_ref <= 1'b1;
          if (verdict == SPC_OK) begin
            one_ok <= 1'b1;
            if (one_ok) link_q <= 1'b1;
          end else begin
            one_ok <= 1'b0;
          end
        end
        if (rx_active) link_q <= 1'b1;
      end
    end
  end

  assign link_good = link_q;

  p_rise_needs_activity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_good) |-> $past(rx_active || rx_pulse));

  p_early_no_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pulse && verdict == SPC_EARLY && !rx_active && !link_good) |=> !link_good);

  p_packet_sets_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |=> link_good);

  p_loss_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loss_hit |=> !link_good);
endmodule

// File: rtl/tlp_link_pulse.sv
module tlp_link_pulse #(
  parameter int unsigned TICK_DIV   = 25000,
  parameter int unsigned TX_GAP     = 16,
  parameter int unsigned PULSE_CLKS = 3,
  parameter int unsigned MIN_GAP    = 5,
  parameter int unsigned MAX_GAP    = 52,
  parameter int unsigned LOSS_TICKS = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic rx_active,
  input  logic rx_pulse,
  output logic tx_pulse_req,
  output logic tx_pulse_en,
  output logic link_good
);
  logic tick;

  tlp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  tlp_tx_sched #(.TX_GAP(TX_GAP), .PULSE_CLKS(PULSE_CLKS)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .tx_active   (tx_active),
    .tx_pulse_req(tx_pulse_req),
    .tx_pulse_en (tx_pulse_en)
  );

  tlp_rx_judge #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP), .LOSS_TICKS(LOSS_TICKS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rx_active(rx_active),
    .rx_pulse (rx_pulse),
    .link_good(link_good)
  );

  // R1: outputs idle in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!tx_pulse_req && !tx_pulse_en && !link_good));
endmodule

// File: tb/tlp_link_pulse_test.sv
`timescale 1ns/1ps
module tlp_link_pulse_test;
  localparam int DIV = 10;
  localparam int GAP = 16;
  localparam int PW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0, rx_active = 1'b0, rx_pulse = 1'b0;
  logic tx_pulse_req, tx_pulse_en, link_good;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses_seen = 0;
  int last_pulse = 0;
  int en_run = 0;
  bit done = 0;

  typedef struct { bit rel; int lo; int hi; } win_t;
  win_t expq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tlp_link_pulse #(.TICK_DIV(DIV), .TX_GAP(GAP), .PULSE_CLKS(PW),
                   .MIN_GAP(5), .MAX_GAP(20), .LOSS_TICKS(40)) uut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .rx_pulse(rx_pulse), .tx_pulse_req(tx_pulse_req),
    .tx_pulse_en(tx_pulse_en), .link_good(link_good));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_range(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rx();
    @(negedge clk) rx_pulse = 1'b1;
    @(negedge clk) rx_pulse = 1'b0;
  endtask

  // Scoreboard monitor: each request pops an expected window.
  always @(negedge clk) begin
    if (rst_n && tx_pulse_req) begin
      if (expq.size() == 0) begin
        chk("R4 unexpected pulse request", 1, 0);
      end else begin
        win_t w;
        int base;
        w = expq.pop_front();
        base = w.rel ? last_pulse : 0;
        if (w.rel) chk_range("R2 idle spacing", cyc - base, w.lo, w.hi);
        else       chk_range("R4 first pulse window", cyc, w.lo, w.hi);
      end
      last_pulse = cyc;
      pulses_seen++;
    end
    if (tx_pulse_en) en_run++;
    else if (en_run != 0) begin
      chk("R3 pulse width", en_run, PW);
      en_run = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r, e;
    wait_n(5);
    chk("R1 req in reset", tx_pulse_req, 0);
    chk("R1 en in reset", tx_pulse_en, 0);
    chk("R1 link in reset", link_good, 0);
    rst_n = 1'b1;
    r = cyc;
    @(negedge clk);
    chk("R1 link after reset", link_good, 0);

    // R2: idle cadence from reset
    expq.push_back('{0, r + (GAP-1)*DIV, r + GAP*DIV + 4});
    expq.push_back('{1, GAP*DIV, GAP*DIV});
    expq.push_back('{1, GAP*DIV, GAP*DIV});
    wait (pulses_seen == 3);
    // R4: traffic across the due time cancels, then restarts the cadence
    wait_n(50);
    tx_active = 1'b1;
    wait_n(200);
    tx_active = 1'b0;
    e = cyc;
    expq.push_back('{0, e + (GAP-1)*DIV, e + GAP*DIV + 3});
    wait (pulses_seen == 4);
    wait_n(5);
    tx_active = 1'b1;

    // R5: two valid spacings needed
    pulse_rx(); wait_n(99);
    pulse_rx(); wait_n(5);
    chk("R5 one valid spacing", link_good, 0);
    wait_n(94);
    pulse_rx(); wait_n(3);
    chk("R5 two valid spacings", link_good, 1);
    wait_n(380);
    chk("R9 link held before loss", link_good, 1);
    wait_n(20);
    chk("R9 link lost", link_good, 0);

    // R6: early pulse clears the count and becomes reference
    pulse_rx(); wait_n(99);
    pulse_rx(); wait_n(19);
    pulse_rx(); wait_n(99);
    pulse_rx(); wait_n(3);
    chk("R6 early pulse not counted", link_good, 0);
    wait_n(96);
    pulse_rx(); wait_n(3);
    chk("R6 link after recount", link_good, 1);
    wait_n(410);
    chk("R9 link lost after early test", link_good, 0);

    // R7: late pulse is a violation
    pulse_rx(); wait_n(299);
    pulse_rx(); wait_n(99);
    pulse_rx(); wait_n(3);
    chk("R7 late spacing not counted", link_good, 0);
    wait_n(96);
    pulse_rx(); wait_n(3);
    chk("R7 link after recount", link_good, 1);
    wait_n(410);
    chk("R9 link lost after late test", link_good, 0);

    // R8: packet activity sets and holds link
    @(negedge clk) rx_active = 1'b1;
    @(negedge clk);
    chk("R8 link next cycle", link_good, 1);
    wait_n(600);
    chk("R8 link held during packet", link_good, 1);
    rx_active = 1'b0;
    wait_n(385);
    chk("R9 link held after packet", link_good, 1);
    wait_n(20);
    chk("R9 link lost after packet", link_good, 0);

    chk("R4 no pending expected pulses", expq.size(), 0);
    finish_run();
  end
endmodule